// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Its logical specifier space is split in two. The low region holds fixed registers, addressed one to one. The high region holds rotating registers. For the rotating region, a base offset is added to the specifier, modulo the region size, to give the physical register. A loop-branch strobe lowers the base by one. A value written as logical register k in one iteration is therefore read as register k+1 in the next. A schedule can thus express a producer latency of N iterations as a specifier distance of N, with no copies between iterations.

The block has one write port and two read ports. All three translate their specifiers through the same base. The base returns to zero on reset. It can be loaded explicitly with a value, for example to clear it at loop entry. Reads are combinational. The write, the base step and the base load all take effect on the rising clock edge.

Top module: `rot_regfile`

## Requirements
- R1: After reset every register reads as zero and the base is zero, so every specifier maps to the physical register of the same number.
- R2: A specifier below 32 addresses physical register `spec` whatever the base.
- R3: A specifier from 32 to 63 addresses physical register 32 + ((spec - 32 + base) mod 32).
- R4: When `loop_step` is high and `base_load` is low at an edge, the base drops by one, and a base of 0 becomes 31. A value written as rotating specifier k is then read as k+1, and 63 is followed by 32.
- R5: When `base_load` is high at an edge, the base takes `base_value`. This holds even if `loop_step` is also high.
- R6: A write in the same cycle as a base step or load lands in the register selected by the base from before that change.
- R7: A read of the physical register being written in the same cycle returns the old value. The new value is seen from the next cycle on.
- R8: With `wr_en` low, no register changes, whatever `wr_spec` and `wr_data` hold.
- R9: The two read ports translate and return data independently of each other, under the same base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_step | input | 1 | Loop-branch strobe: lower the base by one |
| base_load | input | 1 | Load the base from `base_value` |
| base_value | input | 5 | Value for an explicit base load |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 6 | Logical specifier of the write |
| wr_data | input | 32 | Write data |
| rd0_spec | input | 6 | Logical specifier of read port 0 |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_spec | input | 6 | Logical specifier of read port 1 |
| rd1_data | output | 32 | Read port 1 data, combinational |

## Verification
Read data is due in the same cycle as its specifier. The bench drives inputs 2 ns after the falling edge and compares both read ports before the next rising edge. It then advances its own model of the registers and the base on that edge. A write, a base step and a base load are due one edge later. Each is checked by a read issued in the following cycle, never in the cycle of the change itself. The one exception is the same-cycle collision of R7, which is checked on purpose to return the old value.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  typedef enum logic [1:0] {
    BASE_HOLD = 2'd0,
    BASE_STEP = 2'd1,
    BASE_LOAD = 2'd2
  } base_act_e;

  // logical specifier to physical index; rotating part offset modulo nrot
  function automatic int unsigned map_spec(int unsigned spec, int unsigned base,
                                           int unsigned nfix, int unsigned nrot);
    int unsigned off;
    if (spec < nfix) return spec;
    off = spec - nfix + base;
    if (off >= nrot) off = off - nrot;
    return nfix + off;
  endfunction

  // base after one loop branch: down by one with wrap
  function automatic int unsigned step_down(int unsigned b, int unsigned nrot);
    return (b == 0) ? nrot - 1 : b - 1;
  endfunction

endpackage

// File: rtl/rrf_base_ctr.sv
module rrf_base_ctr #(
  parameter int NROT = 32,
  localparam int BW = $clog2(NROT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loop_step,
  input  logic               base_load,
  input  logic [BW-1:0]      base_value,
  output rrf_pkg::base_act_e base_act,
  output logic [BW-1:0]      base_q
);
  import rrf_pkg::*;

  always_comb begin
    if (base_load)      base_act = BASE_LOAD;
    else if (loop_step) base_act = BASE_STEP;
    else                base_act = BASE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else begin
      case (base_act)
        BASE_LOAD: base_q <= base_value;
        BASE_STEP: base_q <= BW'(step_down(32'(base_q), NROT));
        default:   base_q <= base_q;
      endcase
    end
  end
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate #(
  parameter int NFIX = 32,
  parameter int NROT = 32,
  localparam int SW = $clog2(NFIX + NROT),
  localparam int BW = $clog2(NROT)
) (
  input  logic [SW-1:0] spec,
  input  logic [BW-1:0] base,
  output logic [SW-1:0] phys
);
  always_comb begin
    phys = SW'(rrf_pkg::map_spec(32'(spec), 32'(base), NFIX, NROT));
  end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
  parameter int NREG = 64,
  parameter int DW = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr0,
  output logic [DW-1:0] rdata0,
  input  logic [AW-1:0] raddr1,
  output logic [DW-1:0] rdata1
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // combinational reads: a same-cycle write is not yet visible
  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int NFIX = 32,
  parameter int NROT = 32,
  parameter int DW   = 32,
  localparam int NREG = NFIX + NROT,
  localparam int SW   = $clog2(NREG),
  localparam int BW   = $clog2(NROT),
  localparam int NPORT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_step,
  input  logic          base_load,
  input  logic [BW-1:0] base_value,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_spec,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd0_spec,
  output logic [DW-1:0] rd0_data,
  input  logic [SW-1:0] rd1_spec,
  output logic [DW-1:0] rd1_data
);
  rrf_pkg::base_act_e base_act;
  logic [BW-1:0] base_q;
  logic [SW-1:0] spec_v [NPORT];
  logic [SW-1:0] phys_v [NPORT];
  logic [SW-1:0] wr_phys, rd0_phys, rd1_phys;

  rrf_base_ctr #(.NROT(NROT)) u_base (
    .clk(clk), .rst_n(rst_n), .loop_step(loop_step), .base_load(base_load),
    .base_value(base_value), .base_act(base_act), .base_q(base_q)
  );

  assign spec_v[0] = wr_spec;
  assign spec_v[1] = rd0_spec;
  assign spec_v[2] = rd1_spec;

  for (genvar p = 0; p < NPORT; p++) begin : g_xlate
    rrf_xlate #(.NFIX(NFIX), .NROT(NROT)) u_xl (
      .spec(spec_v[p]), .base(base_q), .phys(phys_v[p])
    );
  end

  assign wr_phys  = phys_v[0];
  assign rd0_phys = phys_v[1];
  assign rd1_phys = phys_v[2];

  rrf_storage #(.NREG(NREG), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_phys), .wdata(wr_data),
    .raddr0(rd0_phys), .rdata0(rd0_data), .raddr1(rd1_phys), .rdata1(rd1_data)
  );
endmodule

// File: rtl/rot_regfile_chk.sv
module rot_regfile_chk #(
  parameter int NFIX = 32,
  parameter int NROT = 32,
  parameter int DW   = 32,
  localparam int SW  = $clog2(NFIX + NROT),
  localparam int BW  = $clog2(NROT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loop_step,
  input logic          base_load,
  input logic [BW-1:0] base_value,
  input logic [BW-1:0] base_q,
  input logic          wr_en,
  input logic [SW-1:0] wr_spec,
  input logic [DW-1:0] wr_data,
  input logic [SW-1:0] rd0_spec,
  input logic [SW-1:0] rd0_phys,
  input logic [DW-1:0] rd0_data
);
  a_r2_fixed_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_spec < SW'(NFIX)) |-> (rd0_phys == rd0_spec));

  a_r3_stays_rotating: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_spec >= SW'(NFIX)) |-> (rd0_phys >= SW'(NFIX)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_step && !base_load) |=> (base_q == $past(base_q) - BW'(1)));

  a_r4_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_step && !base_load) |=> $stable(base_q));

  a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    base_load |=> (base_q == $past(base_value)));

  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !loop_step && !base_load) |=>
      ((rd0_spec != $past(wr_spec)) || (rd0_data == $past(wr_data))));
endmodule

bind rot_regfile rot_regfile_chk #(.NFIX(NFIX), .NROT(NROT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_step(loop_step), .base_load(base_load),
  .base_value(base_value), .base_q(base_q), .wr_en(wr_en), .wr_spec(wr_spec),
  .wr_data(wr_data), .rd0_spec(rd0_spec), .rd0_phys(rd0_phys), .rd0_data(rd0_data)
);

// File: tb/rot_regfile_bench.sv
module rot_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loop_step = 1'b0, base_load = 1'b0, wr_en = 1'b0;
  logic [4:0]  base_value = '0;
  logic [5:0]  wr_spec = '0, rd0_spec = '0, rd1_spec = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd0_data, rd1_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rot_regfile u_rot_regfile (
    .clk(clk), .rst_n(rst_n), .loop_step(loop_step), .base_load(base_load),
    .base_value(base_value), .wr_en(wr_en), .wr_spec(wr_spec), .wr_data(wr_data),
    .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rd1_spec(rd1_spec), .rd1_data(rd1_data)
  );

  // independent model: physical contents and base
  logic [31:0] m_reg [64];
  int m_base;

  function automatic int m_phys(int spec);
    if (spec < 32) return spec;
    return 32 + ((spec + m_base) & 31);
  endfunction

  typedef struct packed {
    logic [3:0]  tag;
    logic        we;
    logic [5:0]  ws;
    logic [31:0] wd;
    logic        st;
    logic        ld;
    logic [4:0]  lv;
    logic [5:0]  r0;
    logic [5:0]  r1;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd7, 1'b1, 6'd5,  32'h1111_0005, 1'b0, 1'b0, 5'd0,  6'd5,  6'd5 },
    '{4'd3, 1'b1, 6'd40, 32'hA0A0_0040, 1'b0, 1'b0, 5'd0,  6'd5,  6'd40},
    '{4'd9, 1'b0, 6'd0,  32'h0,         1'b1, 1'b0, 5'd0,  6'd40, 6'd41},
    '{4'd3, 1'b1, 6'd41, 32'hB1B1_0041, 1'b0, 1'b0, 5'd0,  6'd41, 6'd40},
    '{4'd6, 1'b1, 6'd63, 32'hC3C3_0063, 1'b0, 1'b1, 5'd10, 6'd63, 6'd41},
    '{4'd3, 1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 5'd0,  6'd63, 6'd53},
    '{4'd6, 1'b1, 6'd33, 32'hD3D3_0033, 1'b1, 1'b0, 5'd0,  6'd33, 6'd34},
    '{4'd9, 1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 5'd0,  6'd34, 6'd33},
    '{4'd2, 1'b1, 6'd31, 32'hF1F1_0031, 1'b1, 1'b0, 5'd0,  6'd31, 6'd0 },
    '{4'd2, 1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 5'd0,  6'd31, 6'd5 },
    '{4'd8, 1'b0, 6'd31, 32'hDEAD_BEEF, 1'b0, 1'b0, 5'd0,  6'd31, 6'd35},
    '{4'd5, 1'b0, 6'd0,  32'h0,         1'b1, 1'b1, 5'd31, 6'd35, 6'd36},
    '{4'd7, 1'b1, 6'd36, 32'h7777_0036, 1'b0, 1'b0, 5'd0,  6'd36, 6'd36},
    '{4'd9, 1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 5'd0,  6'd36, 6'd35}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(logic we, logic [5:0] ws, logic [31:0] wd, logic st, logic ld,
                     logic [4:0] lv, logic [5:0] r0, logic [5:0] r1);
    @(negedge clk);
    #2;
    wr_en = we; wr_spec = ws; wr_data = wd; loop_step = st;
    base_load = ld; base_value = lv; rd0_spec = r0; rd1_spec = r1;
    #2;
  endtask

  // compare both ports with the model, then advance the model on the edge
  task automatic tick(string tag);
    check(tag, rd0_data, m_reg[m_phys(int'(rd0_spec))]);
    check(tag, rd1_data, m_reg[m_phys(int'(rd1_spec))]);
    @(posedge clk);
    if (wr_en) m_reg[m_phys(int'(wr_spec))] = wr_data;
    if (base_load) m_base = int'(base_value);
    else if (loop_step) m_base = (m_base + 31) & 31;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 0; loop_step = 0; base_load = 0; base_value = '0;
    wr_spec = '0; wr_data = '0; rd0_spec = '0; rd1_spec = '0;
    for (int i = 0; i < 64; i++) m_reg[i] = '0;
    m_base = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state, every register zero, identity mapping
    for (int s = 0; s < 64; s += 7) begin
      put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'(s), 6'(63 - s));
      check("R1", rd0_data, 32'h0);
      check("R1", rd1_data, 32'h0);
      tick("R1");
    end

    // table walk against the model
    for (int v = 0; v < NV; v++) begin
      put(VEC[v].we, VEC[v].ws, VEC[v].wd, VEC[v].st, VEC[v].ld, VEC[v].lv,
          VEC[v].r0, VEC[v].r1);
      tick(tag_name(VEC[v].tag));
    end

    // directed corner cases with hand-computed values
    do_reset();
    // R2: fixed region ignores the base
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b1, 5'd17, 6'd0, 6'd0); tick("R2");
    put(1'b1, 6'd5, 32'h0000_0055, 1'b0, 1'b0, 5'd0, 6'd5, 6'd0); tick("R2");
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd5, 6'd37);
    check("R2", rd0_data, 32'h0000_0055);
    check("R3", rd1_data, 32'h0);
    tick("R2");

    // R4: k becomes k+1 after a step
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b1, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b1, 6'd40, 32'h0000_00A4, 1'b0, 1'b0, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b0, 6'd0, 32'h0, 1'b1, 1'b0, 5'd0, 6'd40, 6'd0); tick("R4");
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd41, 6'd0);
    check("R4", rd0_data, 32'h0000_00A4);
    tick("R4");

    // R4: base wraps from 0 to 31, specifier 63 followed by 32
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b1, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b1, 6'd32, 32'h0000_00C0, 1'b0, 1'b0, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b1, 6'd63, 32'h0000_00E3, 1'b0, 1'b0, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b0, 6'd0, 32'h0, 1'b1, 1'b0, 5'd0, 6'd0, 6'd0); tick("R4");
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd33, 6'd32);
    check("R4", rd0_data, 32'h0000_00C0);
    check("R4", rd1_data, 32'h0000_00E3);
    tick("R4");

    // R5: load beats step in the same cycle
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b1, 5'd0, 6'd0, 6'd0); tick("R5");
    put(1'b1, 6'd37, 32'h0000_00D7, 1'b0, 1'b0, 5'd0, 6'd0, 6'd0); tick("R5");
    put(1'b0, 6'd0, 32'h0, 1'b1, 1'b1, 5'd5, 6'd0, 6'd0); tick("R5");
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd32, 6'd0);
    check("R5", rd0_data, 32'h0000_00D7);
    tick("R5");

    // R6: write with a step uses the old base (5): spec 32 -> phys 37
    put(1'b1, 6'd32, 32'h0000_00E6, 1'b1, 1'b0, 5'd0, 6'd0, 6'd0); tick("R6");
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd33, 6'd0);
    check("R6", rd0_data, 32'h0000_00E6);
    tick("R6");

    // R7: same-cycle read returns old value, then new
    put(1'b1, 6'd3, 32'h0000_0077, 1'b0, 1'b0, 5'd0, 6'd3, 6'd3);
    check("R7", rd0_data, 32'h0);
    check("R7", rd1_data, 32'h0);
    tick("R7");
    put(1'b0, 6'd3, 32'h0000_0BAD, 1'b0, 1'b0, 5'd0, 6'd3, 6'd4);
    check("R7", rd0_data, 32'h0000_0077);
    tick("R8");
    // R8: disabled write left register 3 untouched
    put(1'b0, 6'd0, 32'h0, 1'b0, 1'b0, 5'd0, 6'd3, 6'd3);
    check("R8", rd0_data, 32'h0000_0077);
    check("R9", rd1_data, 32'h0000_0077);
    tick("R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule